// File: doc/BRIEF.md
# Caption Byte-Pair Inserter

This block carries two bytes of line-21 style caption data from a host into the video timing. The host loads a first byte, a second byte and a control byte through a small write port. The timing generator supplies three inputs: a one-cycle pulse on each falling edge of horizontal sync, the number of the line that this edge starts, and a flag that is high in even fields. When enabled, the block watches for the sync edge that opens the chosen line of the chosen field. On that edge it moves a 16-bit word into a transmit shift register. The word is either the host's byte pair or a pair of null bytes.

The host signals a fresh pair by setting a request bit in the control byte. Hardware clears that bit at the moment it takes the bytes, and the host sees its state on `rts_pending`. Once the latch has cleared the bit, the host may load the next pair without disturbing the word being sent. The serializer sends the 16 bits first byte first, least significant bit first, and holds each bit for a number of clock cycles set at a port. A one-cycle done pulse follows the last bit. Both data bytes can optionally have their top bit replaced by an odd-parity bit.

Top module: `cc_pair_inserter`

## Requirements
- R1: The write port has three addresses. Address 0 holds the first byte, address 1 the second byte and address 2 the control byte. Writes to address 3 are ignored. All three registers reset to 00h, and after reset `cc_valid`, `cc_bit`, `cc_done` and `rts_pending` are all 0.
- R2: The control byte has these fields: bit 7 enable, bit 6 request-to-send, bit 5 parity enable, bit 4 field select, and bits 3..0 line select. `rts_pending` shows bit 6.
- R3: A transfer starts on a cycle with `hs_fall`=1, enable=1, a field match and a line match. On that cycle, if request-to-send is 1, the two data bytes are latched and the request bit is cleared to 0 on the same clock edge.
- R4: If a transfer starts while request-to-send is 0, the block sends the null word, which is 80h for both bytes, and the data registers are not used.
- R5: With parity enable set, bit 7 of each sent byte is replaced by the odd parity of that byte's bits 6..0, so the byte always has an odd number of ones. With parity enable clear, the 16 bits go out exactly as written.
- R6: Field select 0 matches `field_even`=0 (odd fields), and field select 1 matches `field_even`=1. A field mismatch sends nothing and leaves the request bit set.
- R7: A line matches when `line_next` equals the line select plus LINE_OFS (default 11). Line select 0 gives line 11, 10 gives line 21 and 15 gives line 26. Any other line sends nothing.
- R8: The bits go out starting the cycle after the latching edge. The order is first byte bit 0 through bit 7, then second byte bit 0 through bit 7. Each bit is held for `bit_period` cycles, and 0 counts as 1. `cc_valid` is 1 while a bit is on `cc_bit`. While `cc_valid` is 0, `cc_bit` is 0.
- R9: `cc_done` is high for exactly one cycle, directly after the last bit, and `cc_valid` is 0 in that cycle.
- R10: Host writes to any register while a word is being sent do not change the bits of that word.
- R11: If a host control write falls on the latching cycle, the transfer uses the register values from before the write. The written control byte, including its request bit, is what remains stored afterwards.
- R12: With enable clear, no sync edge starts a transfer and the request bit stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 2 | Register address for the write |
| wr_data | input | 8 | Write data |
| hs_fall | input | 1 | One-cycle pulse at the falling edge of horizontal sync |
| line_next | input | LINE_W | Number of the line that this sync edge begins |
| field_even | input | 1 | High during even fields |
| bit_period | input | CNT_W | Clock cycles per caption bit (0 treated as 1) |
| rts_pending | output | 1 | Current value of the request-to-send bit |
| cc_valid | output | 1 | High while a caption bit is being presented |
| cc_bit | output | 1 | Serial caption data |
| cc_done | output | 1 | One-cycle pulse after the 16th bit |

## Verification
The host write path and the hardware latch both act on the control byte and the data bytes, and they can fall on the same clock edge. The bench provokes this by presenting a control write in the same cycle as a matching `hs_fall` pulse, once with a request bit and once with enable cleared. It judges the result in two places: the serial word must carry the values that were in the registers before the write, and `rts_pending` afterwards must show the newly written request bit. A second overlap is checked the same way: data writes land partway through a transfer, and the remaining bits on `cc_bit` must be unchanged.

// File: rtl/cc_pair_inserter.sv
module cc_pair_inserter #(
  parameter int LINE_W   = 10,
  parameter int CNT_W    = 8,
  parameter int LINE_OFS = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              hs_fall,
  input  logic [LINE_W-1:0] line_next,
  input  logic              field_even,
  input  logic [CNT_W-1:0]  bit_period,
  output logic              rts_pending,
  output logic              cc_valid,
  output logic              cc_bit,
  output logic              cc_done
);

  localparam int WORD_W = 16;
  localparam int IDX_W  = $clog2(WORD_W);

  logic [7:0]        byte_a, byte_b, ctrl_q;
  logic [WORD_W-1:0] sreg;
  logic [CNT_W-1:0]  tcnt;
  logic [IDX_W-1:0]  bidx;
  logic              busy, done_q;

  function automatic logic [7:0] with_par(input logic [7:0] b, input logic en);
    with_par = en ? {~^b[6:0], b[6:0]} : b;
  endfunction

  wire ctrl_wr   = wr_en && (wr_addr == 2'd2);
  wire line_hit  = line_next == (LINE_W'(ctrl_q[3:0]) + LINE_W'(LINE_OFS));
  wire field_hit = ctrl_q[4] == field_even;
  wire take      = hs_fall && ctrl_q[7] && line_hit && field_hit;
  wire [CNT_W-1:0] plen = (bit_period == '0) ? CNT_W'(1) : bit_period;
  wire bit_end   = busy && (tcnt == plen - CNT_W'(1));

  wire [WORD_W-1:0] load_word = ctrl_q[6]
    ? {with_par(byte_b, ctrl_q[5]), with_par(byte_a, ctrl_q[5])}
    : 16'h8080;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_a <= '0;
      byte_b <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_en && wr_addr == 2'd0) byte_a <= wr_data;
      if (wr_en && wr_addr == 2'd1) byte_b <= wr_data;
      if (ctrl_wr)                  ctrl_q <= wr_data;
      else if (take)                ctrl_q[6] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg   <= '0;
      tcnt   <= '0;
      bidx   <= '0;
      busy   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        sreg <= load_word;
        tcnt <= '0;
        bidx <= '0;
        busy <= 1'b1;
      end else if (bit_end) begin
        tcnt <= '0;
        sreg <= sreg >> 1;
        if (bidx == IDX_W'(WORD_W - 1)) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end else begin
          bidx <= bidx + IDX_W'(1);
        end
      end else if (busy) begin
        tcnt <= tcnt + CNT_W'(1);
      end
    end
  end

  assign rts_pending = ctrl_q[6];
  assign cc_valid    = busy;
  assign cc_bit      = busy & sreg[0];
  assign cc_done     = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cc_done |=> !cc_done); // R9
  AST_DONE_AFTER_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    cc_done |-> (!cc_valid && $past(cc_valid))); // R9
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cc_valid |-> !cc_bit); // R8
  AST_RTS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ctrl_wr) |=> !rts_pending); // R3
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_valid && $past(cc_valid) && tcnt != '0) |-> $stable(cc_bit)); // R8
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cc_valid && !ctrl_q[7]) |=> !cc_valid); // R12

endmodule

// File: tb/cc_pair_inserter_bench.sv
module cc_pair_inserter_bench;
  logic clk = 0, rst_n = 0, wr_en = 0, hs_fall = 0, field_even = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [9:0] line_next = 0;
  logic [7:0] bit_period = 8'd2;
  logic rts_pending, cc_valid, cc_bit, cc_done;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  cc_pair_inserter u_cc_pair_inserter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hs_fall(hs_fall), .line_next(line_next), .field_even(field_even),
    .bit_period(bit_period), .rts_pending(rts_pending), .cc_valid(cc_valid),
    .cc_bit(cc_bit), .cc_done(cc_done));

  typedef struct packed {
    logic [7:0]  b1;
    logic [7:0]  b2;
    logic [7:0]  ctl;
    logic [9:0]  line;
    logic        fld;
    logic        sent;
    logic [15:0] word;
    logic        rts;
  } vec_t;

  localparam vec_t TBL [9] = '{
    '{8'h41, 8'h42, 8'hC0, 10'd11, 1'b0, 1'b1, 16'h4241, 1'b0}, // R3 R8 plain pair
    '{8'h41, 8'h43, 8'hE0, 10'd11, 1'b0, 1'b1, 16'h43C1, 1'b0}, // R5 parity
    '{8'hFF, 8'h00, 8'hE0, 10'd11, 1'b0, 1'b1, 16'h807F, 1'b0}, // R5 msb overwritten
    '{8'hFF, 8'hFF, 8'hC0, 10'd11, 1'b0, 1'b1, 16'hFFFF, 1'b0}, // R5 no parity
    '{8'h55, 8'h66, 8'h80, 10'd11, 1'b0, 1'b1, 16'h8080, 1'b0}, // R4 null
    '{8'h14, 8'h20, 8'hDA, 10'd21, 1'b1, 1'b1, 16'h2014, 1'b0}, // R6 R7 even, line 21
    '{8'h14, 8'h20, 8'hDA, 10'd21, 1'b0, 1'b0, 16'h0000, 1'b1}, // R6 field mismatch
    '{8'h33, 8'h44, 8'hC0, 10'd12, 1'b0, 1'b0, 16'h0000, 1'b1}, // R7 line mismatch
    '{8'h33, 8'h44, 8'h40, 10'd11, 1'b0, 1'b0, 16'h0000, 1'b1}  // R12 disabled
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse(input logic [9:0] ln, input logic f);
    @(negedge clk); hs_fall = 1; line_next = ln; field_even = f;
    @(negedge clk); hs_fall = 0;
  endtask

  task automatic capture(input int p, output logic [15:0] w, output bit vok, output bit dok);
    vok = 1; w = 0;
    for (int k = 0; k < 16; k++) begin
      if (!cc_valid) vok = 0;
      w[k] = cc_bit;
      repeat (p) @(negedge clk);
    end
    dok = cc_done && !cc_valid;
    @(negedge clk);
    if (cc_done) dok = 0;
  endtask

  task automatic quiet(output bit q);
    q = 1;
    repeat (6) begin
      if (cc_valid) q = 0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] w;
    bit vok, dok, q;
    repeat (3) @(negedge clk);
    chk(!cc_valid && !cc_bit && !cc_done && !rts_pending, "R1 reset outputs",
        {cc_valid, cc_bit, cc_done, rts_pending}, 0);
    rst_n = 1;
    @(negedge clk);
    wr(2'd2, 8'h80);
    pulse(10'd11, 1'b0);
    capture(2, w, vok, dok);
    chk(w == 16'h8080, "R1 reset data unused, null sent", w, 16'h8080);

    for (int i = 0; i < 9; i++) begin
      wr(2'd0, TBL[i].b1); wr(2'd1, TBL[i].b2); wr(2'd2, TBL[i].ctl);
      chk(rts_pending == TBL[i].ctl[6], "R2 rts bit 6", rts_pending, TBL[i].ctl[6]);
      pulse(TBL[i].line, TBL[i].fld);
      if (TBL[i].sent) begin
        capture(2, w, vok, dok);
        chk(vok && w == TBL[i].word, "R8 word", w, TBL[i].word);
        chk(dok, "R9 done pulse", dok, 1);
      end else begin
        quiet(q);
        chk(q, "R6/R7/R12 nothing sent", !q, 0);
      end
      chk(rts_pending == TBL[i].rts, "R3 rts after edge", rts_pending, TBL[i].rts);
    end

    wr(2'd3, 8'hFF);
    wr(2'd2, 8'hC0);
    pulse(10'd11, 1'b0);
    capture(2, w, vok, dok);
    chk(w == 16'h4433, "R1 addr 3 ignored", w, 16'h4433);

    wr(2'd0, 8'hA5); wr(2'd1, 8'h3C); wr(2'd2, 8'hCF);
    pulse(10'd26, 1'b0);
    capture(2, w, vok, dok);
    chk(vok && w == 16'h3CA5, "R7 line select 15", w, 16'h3CA5);

    bit_period = 8'd0;
    wr(2'd2, 8'hC0);
    pulse(10'd11, 1'b0);
    capture(1, w, vok, dok);
    chk(vok && w == 16'h3CA5 && dok, "R8 period 0 as 1", w, 16'h3CA5);
    bit_period = 8'd3;
    wr(2'd2, 8'hC0);
    pulse(10'd11, 1'b0);
    capture(3, w, vok, dok);
    chk(vok && w == 16'h3CA5 && dok, "R8 period 3", w, 16'h3CA5);

    bit_period = 8'd4;
    wr(2'd2, 8'hC0);
    pulse(10'd11, 1'b0);
    fork
      capture(4, w, vok, dok);
      begin
        repeat (10) @(negedge clk);
        wr_en = 1; wr_addr = 2'd0; wr_data = 8'h00; @(negedge clk);
        wr_addr = 2'd1; wr_data = 8'hFF; @(negedge clk);
        wr_en = 0;
      end
    join
    chk(vok && w == 16'h3CA5, "R10 writes during transfer", w, 16'h3CA5);
    bit_period = 8'd2;

    wr(2'd0, 8'h11); wr(2'd1, 8'h22); wr(2'd2, 8'hC0);
    @(negedge clk);
    hs_fall = 1; line_next = 10'd11; field_even = 0;
    wr_en = 1; wr_addr = 2'd2; wr_data = 8'hC0;
    @(negedge clk); hs_fall = 0; wr_en = 0;
    capture(2, w, vok, dok);
    chk(w == 16'h2211, "R11 old bytes used", w, 16'h2211);
    chk(rts_pending == 1'b1, "R11 host request survives", rts_pending, 1);

    @(negedge clk);
    hs_fall = 1; line_next = 10'd11;
    wr_en = 1; wr_addr = 2'd2; wr_data = 8'h00;
    @(negedge clk); hs_fall = 0; wr_en = 0;
    capture(2, w, vok, dok);
    chk(w == 16'h2211, "R11 old enable used", w, 16'h2211);
    chk(rts_pending == 1'b0, "R11 written value kept", rts_pending, 0);
    pulse(10'd11, 1'b0);
    quiet(q);
    chk(q, "R12 disabled after write", !q, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule